// File: doc/BRIEF.md
# Converter Chip Configuration Sequencer

This block moves 32-bit configuration words between a host register file and an external time-to-digital converter chip. The chip sits on a simple parallel register bus with a chip select, a write strobe, a read strobe, a 4-bit address and a 32-bit data path. Single-cycle command pulses start a job. A job can write the whole configuration set, read it all back, fetch one status or FIFO register, reset the chip through a register write, or start and stop acquisition.

Configuration words come in on one flat vector of 11 slots. Slots 0 to 7 belong to chip addresses 0 to 7. Slot 8 belongs to address 11, slot 9 to address 12 and slot 10 to address 14. Words read from the chip land in a shadow bank of 16 words. The bank is indexed by chip address, and the word for address `a` sits at bits `[a*32 +: 32]` of `shadow_words`. Every pin is a plain control or data level. There is no valid/ready stream at the edge, so the block never applies back-pressure. The host waits for `busy` to fall before it issues the next command.

Top module: `tdc_cfg_sequencer`

## Requirements
- R1: A `cmd_load` pulse writes exactly 11 words, one access each. The addresses come in the order 0,1,2,3,4,5,6,7,11,12,14, and each write carries the configuration slot that belongs to its address.
- R2: A `cmd_readback` pulse performs exactly 11 reads at the addresses of R1, in the same order. Each word read is stored in the shadow word of that address.
- R3: Single-read pulses perform one read each: `cmd_rd_status` reads address 12, `cmd_rd_fifo1` reads 8, `cmd_rd_fifo2` reads 9 and `cmd_rd_start01` reads 10. Each word goes into the shadow word of that address, and no other shadow word changes.
- R4: A `cmd_master_reset` pulse performs one write to address 4. The data is configuration slot 4 with bit 22 forced to 1.
- R5: Every access follows one pattern. First comes one setup cycle with `chip_cs` high and both strobes low. The strobe then stays high for `STRB_CYCLES` cycles, with address and data held steady. Last comes one release cycle with `chip_cs` high and both strobes low. Read data is sampled during the release cycle.
- R6: `busy` rises in the cycle after the accepted pulse. It falls right after the last release cycle, so a job of n accesses holds `busy` high for n*(`STRB_CYCLES`+2) cycles. Any command pulse that arrives while `busy` is high is ignored.
- R7: When idle, `cmd_acq_on` produces a single one-cycle `chip_start` pulse and sets `acq_en` in the next cycle. `cmd_acq_off` clears `acq_en`. Neither command raises `busy`, and both are ignored while `busy` is high.
- R8: After reset, `busy`, `acq_en`, `chip_start`, `chip_cs` and both strobes are low, and every shadow word is zero.
- R9: The write and read strobes are never high together, and the chip bus is idle whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Pulse: write all configuration slots |
| cmd_readback | input | 1 | Pulse: read the configuration set into the shadow bank |
| cmd_rd_status | input | 1 | Pulse: read address 12 |
| cmd_rd_fifo1 | input | 1 | Pulse: read address 8 |
| cmd_rd_fifo2 | input | 1 | Pulse: read address 9 |
| cmd_rd_start01 | input | 1 | Pulse: read address 10 |
| cmd_master_reset | input | 1 | Pulse: write slot 4 with bit 22 set to address 4 |
| cmd_acq_on | input | 1 | Pulse: start acquisition |
| cmd_acq_off | input | 1 | Pulse: stop acquisition |
| cfg_words | input | 11*DATA_W | Configuration slots, slot k at bits [k*DATA_W +: DATA_W] |
| chip_cs | output | 1 | Chip select, active high |
| chip_wr | output | 1 | Write strobe |
| chip_rd | output | 1 | Read strobe |
| chip_addr | output | 4 | Chip register address |
| chip_wdata | output | DATA_W | Write data |
| chip_rdata | input | DATA_W | Read data from the chip |
| chip_start | output | 1 | One-cycle acquisition start pulse |
| acq_en | output | 1 | Timestamp acceptance enable |
| busy | output | 1 | A job is in progress |
| shadow_words | output | 16*DATA_W | Readback words indexed by chip address |

## Verification
The assertions assume that the host raises at most one command pulse in any cycle and that `STRB_CYCLES` is at least one. They also assume the chip holds valid read data through the release cycle. The bench issues each command alone, as a single-cycle pulse driven on the falling clock edge. Its chip model returns a junk word while the read strobe is high and the true register only after the strobe drops, so a capture taken too early cannot pass. Overlapping pulses are sent only while `busy` is high, to show that they are ignored.

// File: rtl/tdcseq_pkg.sv
package tdcseq_pkg;
  localparam int unsigned CHIP_AW      = 4;
  localparam int unsigned SLOT_W       = 4;
  localparam int unsigned CFG_SLOTS    = 11;
  localparam int unsigned SHADOW_DEPTH = 1 << CHIP_AW;
  localparam int unsigned MRESET_BIT   = 22;

  localparam logic [CHIP_AW-1:0] ADDR_MRESET  = 4'd4;
  localparam logic [CHIP_AW-1:0] ADDR_FIFO1   = 4'd8;
  localparam logic [CHIP_AW-1:0] ADDR_FIFO2   = 4'd9;
  localparam logic [CHIP_AW-1:0] ADDR_START01 = 4'd10;
  localparam logic [CHIP_AW-1:0] ADDR_STATUS  = 4'd12;

  typedef enum logic [2:0] {
    JOB_NONE,
    JOB_LOAD,
    JOB_READBACK,
    JOB_SINGLE,
    JOB_MRESET
  } job_e;

  // configuration slot -> chip address (sparse walk order)
  function automatic logic [CHIP_AW-1:0] slot_addr(input logic [SLOT_W-1:0] slot);
    logic [CHIP_AW-1:0] a;
    if (slot < SLOT_W'(8)) a = CHIP_AW'(slot);
    else if (slot == SLOT_W'(8)) a = 4'd11;
    else if (slot == SLOT_W'(9)) a = 4'd12;
    else a = 4'd14;
    return a;
  endfunction
endpackage

// File: rtl/tdcseq_cmd_decode.sv
module tdcseq_cmd_decode
  import tdcseq_pkg::*;
(
  input  logic               busy,
  input  logic               cmd_load,
  input  logic               cmd_readback,
  input  logic               cmd_rd_status,
  input  logic               cmd_rd_fifo1,
  input  logic               cmd_rd_fifo2,
  input  logic               cmd_rd_start01,
  input  logic               cmd_master_reset,
  input  logic               cmd_acq_on,
  input  logic               cmd_acq_off,
  output logic               go,
  output job_e               go_job,
  output logic [CHIP_AW-1:0] go_addr,
  output logic               acq_on_go,
  output logic               acq_off_go
);
  always_comb begin
    go         = 1'b0;
    go_job     = JOB_NONE;
    go_addr    = '0;
    acq_on_go  = 1'b0;
    acq_off_go = 1'b0;
    if (!busy) begin
      if (cmd_load) begin
        go = 1'b1; go_job = JOB_LOAD;
      end else if (cmd_readback) begin
        go = 1'b1; go_job = JOB_READBACK;
      end else if (cmd_rd_status) begin
        go = 1'b1; go_job = JOB_SINGLE; go_addr = ADDR_STATUS;
      end else if (cmd_rd_fifo1) begin
        go = 1'b1; go_job = JOB_SINGLE; go_addr = ADDR_FIFO1;
      end else if (cmd_rd_fifo2) begin
        go = 1'b1; go_job = JOB_SINGLE; go_addr = ADDR_FIFO2;
      end else if (cmd_rd_start01) begin
        go = 1'b1; go_job = JOB_SINGLE; go_addr = ADDR_START01;
      end else if (cmd_master_reset) begin
        go = 1'b1; go_job = JOB_MRESET; go_addr = ADDR_MRESET;
      end else if (cmd_acq_on) begin
        acq_on_go = 1'b1;
      end else if (cmd_acq_off) begin
        acq_off_go = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdcseq_access.sv
module tdcseq_access
  import tdcseq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STRB_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_write,
  input  logic [CHIP_AW-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               chip_cs,
  output logic               chip_wr,
  output logic               chip_rd,
  output logic [CHIP_AW-1:0] chip_addr,
  output logic [DATA_W-1:0]  chip_wdata,
  output logic               release_o,
  output logic               rel_read
);
  localparam int unsigned CNT_W = (STRB_CYCLES < 2) ? 1 : $clog2(STRB_CYCLES + 1);

  typedef enum logic [1:0] {A_IDLE, A_SETUP, A_STRB, A_REL} acc_e;

  acc_e              state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              write_q;
  logic [CHIP_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign accept = req && (state_q == A_IDLE || state_q == A_REL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= A_IDLE;
      cnt_q   <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (accept) begin
        write_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      case (state_q)
        A_IDLE:  if (accept) state_q <= A_SETUP;
        A_SETUP: begin
          state_q <= A_STRB;
          cnt_q   <= '0;
        end
        A_STRB: begin
          if (cnt_q == CNT_W'(STRB_CYCLES - 1)) state_q <= A_REL;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= accept ? A_SETUP : A_IDLE;
      endcase
    end
  end

  assign chip_cs    = (state_q != A_IDLE);
  assign chip_wr    = (state_q == A_STRB) && write_q;
  assign chip_rd    = (state_q == A_STRB) && !write_q;
  assign chip_addr  = addr_q;
  assign chip_wdata = wdata_q;
  assign release_o  = (state_q == A_REL);
  assign rel_read   = (state_q == A_REL) && !write_q;

  // checker state: length of the current strobe run
  logic [CNT_W:0] strb_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) strb_run_q <= '0;
    else if (chip_wr || chip_rd) strb_run_q <= strb_run_q + 1'b1;
    else strb_run_q <= '0;
  end

  p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_wr && chip_rd));
  p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((chip_wr || chip_rd) && $past(chip_wr || chip_rd)) |-> ($stable(chip_addr) && $stable(chip_wdata)));
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(chip_wr || chip_rd) && $past(chip_wr || chip_rd)) |-> (strb_run_q == (CNT_W+1)'(STRB_CYCLES)));
  p_release_follows_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> ($past(chip_wr || chip_rd) && chip_cs && !chip_wr && !chip_rd));
endmodule

// File: rtl/tdcseq_shadow.sv
module tdcseq_shadow
  import tdcseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [CHIP_AW-1:0]             waddr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [SHADOW_DEPTH*DATA_W-1:0] words
);
  for (genvar g = 0; g < SHADOW_DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (we && waddr == CHIP_AW'(g)) word_q <= wdata;
    end
    assign words[g*DATA_W +: DATA_W] = word_q;
  end

  p_no_hole_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr != 4'd13 && waddr != 4'd15));
endmodule

// File: rtl/tdc_cfg_sequencer.sv
module tdc_cfg_sequencer
  import tdcseq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STRB_CYCLES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_load,
  input  logic                           cmd_readback,
  input  logic                           cmd_rd_status,
  input  logic                           cmd_rd_fifo1,
  input  logic                           cmd_rd_fifo2,
  input  logic                           cmd_rd_start01,
  input  logic                           cmd_master_reset,
  input  logic                           cmd_acq_on,
  input  logic                           cmd_acq_off,
  input  logic [CFG_SLOTS*DATA_W-1:0]    cfg_words,
  output logic                           chip_cs,
  output logic                           chip_wr,
  output logic                           chip_rd,
  output logic [CHIP_AW-1:0]             chip_addr,
  output logic [DATA_W-1:0]              chip_wdata,
  input  logic [DATA_W-1:0]              chip_rdata,
  output logic                           chip_start,
  output logic                           acq_en,
  output logic                           busy,
  output logic [SHADOW_DEPTH*DATA_W-1:0] shadow_words
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CFG_SLOTS - 1);

  logic               busy_q, acq_en_q, start_q;
  job_e               job_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               go, acq_on_go, acq_off_go;
  job_e               go_job;
  logic [CHIP_AW-1:0] go_addr;
  logic               release_w, rel_read_w;
  logic               walk_job, last, advance, req, req_write;
  job_e               req_job;
  logic [SLOT_W-1:0]  next_slot;
  logic [CHIP_AW-1:0] req_addr;
  logic [DATA_W-1:0]  req_wdata, slot_word, mreset_word;

  tdcseq_cmd_decode u_dec (
    .busy(busy_q), .cmd_load(cmd_load), .cmd_readback(cmd_readback),
    .cmd_rd_status(cmd_rd_status), .cmd_rd_fifo1(cmd_rd_fifo1),
    .cmd_rd_fifo2(cmd_rd_fifo2), .cmd_rd_start01(cmd_rd_start01),
    .cmd_master_reset(cmd_master_reset), .cmd_acq_on(cmd_acq_on),
    .cmd_acq_off(cmd_acq_off), .go(go), .go_job(go_job), .go_addr(go_addr),
    .acq_on_go(acq_on_go), .acq_off_go(acq_off_go)
  );

  // job walking: pick the next access while the current one releases
  assign walk_job    = (job_q == JOB_LOAD) || (job_q == JOB_READBACK);
  assign last        = walk_job ? (slot_q == LAST_SLOT) : 1'b1;
  assign advance     = busy_q && release_w;
  assign req         = go || (advance && !last);
  assign req_job     = go ? go_job : job_q;
  assign next_slot   = go ? '0 : slot_q + 1'b1;
  assign slot_word   = cfg_words[int'(next_slot)*DATA_W +: DATA_W];
  assign mreset_word = cfg_words[int'(ADDR_MRESET)*DATA_W +: DATA_W] | (DATA_W'(1) << MRESET_BIT);
  assign req_write   = (req_job == JOB_LOAD) || (req_job == JOB_MRESET);

  always_comb begin
    case (req_job)
      JOB_LOAD:     begin req_addr = slot_addr(next_slot); req_wdata = slot_word; end
      JOB_READBACK: begin req_addr = slot_addr(next_slot); req_wdata = '0; end
      JOB_MRESET:   begin req_addr = ADDR_MRESET;          req_wdata = mreset_word; end
      default:      begin req_addr = go_addr;              req_wdata = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      job_q    <= JOB_NONE;
      slot_q   <= '0;
      acq_en_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= acq_on_go;
      if (acq_on_go)  acq_en_q <= 1'b1;
      if (acq_off_go) acq_en_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        job_q  <= go_job;
        slot_q <= '0;
      end else if (advance) begin
        if (last) begin
          busy_q <= 1'b0;
          job_q  <= JOB_NONE;
        end else begin
          slot_q <= next_slot;
        end
      end
    end
  end

  tdcseq_access #(.DATA_W(DATA_W), .STRB_CYCLES(STRB_CYCLES)) u_acc (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .chip_cs(chip_cs),
    .chip_wr(chip_wr), .chip_rd(chip_rd), .chip_addr(chip_addr),
    .chip_wdata(chip_wdata), .release_o(release_w), .rel_read(rel_read_w)
  );

  tdcseq_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we(rel_read_w), .waddr(chip_addr),
    .wdata(chip_rdata), .words(shadow_words)
  );

  assign busy       = busy_q;
  assign acq_en     = acq_en_q;
  assign chip_start = start_q;

  p_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!chip_cs && !chip_wr && !chip_rd));
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !release_w) |=> busy_q);
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |=> !chip_start);
  p_capture_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_read_w |-> $past(chip_rd));
  p_start_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |-> !busy_q);
endmodule

// File: tb/tdc_cfg_sequencer_tb.sv
module tdc_cfg_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int STRB = 2;
  localparam int ACC  = STRB + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 0, cmd_readback = 0, cmd_rd_status = 0, cmd_rd_fifo1 = 0;
  logic cmd_rd_fifo2 = 0, cmd_rd_start01 = 0, cmd_master_reset = 0;
  logic cmd_acq_on = 0, cmd_acq_off = 0;
  logic [11*DW-1:0] cfg_words;
  logic chip_cs, chip_wr, chip_rd, chip_start, acq_en, busy;
  logic [3:0] chip_addr;
  logic [DW-1:0] chip_wdata, chip_rdata;
  logic [16*DW-1:0] shadow_words;

  int tests = 0, fails = 0;
  logic [DW-1:0] mem [16];
  int wr_cnt, rd_cnt;
  logic [3:0] log_addr [32];
  logic [DW-1:0] log_data [32];
  logic prev_cs, prev_strb;
  int run_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_cfg_sequencer #(.DATA_W(DW), .STRB_CYCLES(STRB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_readback(cmd_readback),
    .cmd_rd_status(cmd_rd_status), .cmd_rd_fifo1(cmd_rd_fifo1),
    .cmd_rd_fifo2(cmd_rd_fifo2), .cmd_rd_start01(cmd_rd_start01),
    .cmd_master_reset(cmd_master_reset), .cmd_acq_on(cmd_acq_on),
    .cmd_acq_off(cmd_acq_off), .cfg_words(cfg_words), .chip_cs(chip_cs),
    .chip_wr(chip_wr), .chip_rd(chip_rd), .chip_addr(chip_addr),
    .chip_wdata(chip_wdata), .chip_rdata(chip_rdata), .chip_start(chip_start),
    .acq_en(acq_en), .busy(busy), .shadow_words(shadow_words)
  );

  // chip model: junk while the read strobe is high
  assign chip_rdata = chip_rd ? 32'hDEAD_BEEF : mem[chip_addr];

  function automatic logic [3:0] list_addr(input int k);
    if (k < 8) return 4'(k);
    if (k == 8) return 4'd11;
    if (k == 9) return 4'd12;
    return 4'd14;
  endfunction

  function automatic logic [DW-1:0] cfg(input int k);
    return 32'h1234_0000 ^ (k * 32'h0001_0101);
  endfunction

  function automatic logic [DW-1:0] sh(input int a);
    return shadow_words[a*DW +: DW];
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((chip_wr || chip_rd) && !prev_strb) begin
        check(prev_cs && !(chip_wr && chip_rd), "R5/R9 setup before strobe",
              {30'd0, chip_wr, chip_rd}, 32'd1);
        run_len = 0;
        if (chip_wr) begin
          if (wr_cnt < 32) begin log_addr[wr_cnt] = chip_addr; log_data[wr_cnt] = chip_wdata; end
          mem[chip_addr] = chip_wdata;
          wr_cnt++;
        end else begin
          if (rd_cnt < 32) log_addr[rd_cnt] = chip_addr;
          rd_cnt++;
        end
      end
      if (chip_wr || chip_rd) run_len++;
      if (!(chip_wr || chip_rd) && prev_strb)
        check(run_len == STRB && chip_cs, "R5 strobe width and release", run_len, STRB);
      if (!busy) check(!chip_cs && !chip_wr && !chip_rd, "R9 bus idle when not busy", chip_cs, 0);
    end
    prev_cs = chip_cs;
    prev_strb = chip_wr || chip_rd;
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_load = 1; 1: cmd_readback = 1; 2: cmd_rd_status = 1;
      3: cmd_rd_fifo1 = 1; 4: cmd_rd_fifo2 = 1; 5: cmd_rd_start01 = 1;
      6: cmd_master_reset = 1; 7: cmd_acq_on = 1; default: cmd_acq_off = 1;
    endcase
    @(negedge clk);
    {cmd_load, cmd_readback, cmd_rd_status, cmd_rd_fifo1, cmd_rd_fifo2,
     cmd_rd_start01, cmd_master_reset, cmd_acq_on, cmd_acq_off} = '0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0; rd_cnt = 0;
  endtask

  task automatic t_reset_state();
    bit z = 1;
    for (int a = 0; a < 16; a++) if (sh(a) != 0) z = 0;
    check(!busy && !acq_en && !chip_start && !chip_cs && !chip_wr && !chip_rd,
          "R8 outputs after reset", {busy, acq_en, chip_start, chip_cs}, 0);
    check(z, "R8 shadow zero after reset", sh(0), 0);
  endtask

  task automatic t_readback();
    int cyc;
    clear_log();
    pulse(1);
    check(busy, "R6 busy after readback pulse", busy, 1);
    wait_idle(cyc);
    check(cyc == 11*ACC, "R6 readback busy length", cyc, 11*ACC);
    check(rd_cnt == 11 && wr_cnt == 0, "R2 readback access count", rd_cnt, 11);
    for (int k = 0; k < 11; k++) begin
      check(log_addr[k] == list_addr(k), "R2 readback order", log_addr[k], list_addr(k));
      check(sh(list_addr(k)) == mem[list_addr(k)], "R2 shadow word",
            sh(list_addr(k)), mem[list_addr(k)]);
    end
    check(sh(8) == 0 && sh(13) == 0, "R2 unlisted shadow untouched", sh(8), 0);
  endtask

  task automatic t_load();
    int cyc;
    clear_log();
    pulse(0);
    wait_idle(cyc);
    check(cyc == 11*ACC, "R6 load busy length", cyc, 11*ACC);
    check(wr_cnt == 11 && rd_cnt == 0, "R1 load access count", wr_cnt, 11);
    for (int k = 0; k < 11; k++) begin
      check(log_addr[k] == list_addr(k), "R1 load order", log_addr[k], list_addr(k));
      check(log_data[k] == cfg(k), "R1 load data", log_data[k], cfg(k));
    end
  endtask

  task automatic t_single_reads();
    int cyc;
    logic [3:0] addrs [4] = '{4'd12, 4'd8, 4'd9, 4'd10};
    logic [DW-1:0] before14;
    for (int i = 0; i < 4; i++) begin
      before14 = sh(14);
      clear_log();
      pulse(2 + i);
      wait_idle(cyc);
      check(cyc == ACC, "R3 single read length", cyc, ACC);
      check(rd_cnt == 1 && log_addr[0] == addrs[i], "R3 single read address", log_addr[0], addrs[i]);
      check(sh(addrs[i]) == mem[addrs[i]], "R3 single read captured", sh(addrs[i]), mem[addrs[i]]);
      check(sh(14) == before14, "R3 other shadow unchanged", sh(14), before14);
    end
  endtask

  task automatic t_master_reset();
    int cyc;
    clear_log();
    pulse(6);
    wait_idle(cyc);
    check(wr_cnt == 1 && rd_cnt == 0 && log_addr[0] == 4'd4, "R4 reset write address", log_addr[0], 4);
    check(log_data[0] == (cfg(4) | 32'h0040_0000), "R4 reset write data", log_data[0], cfg(4) | 32'h0040_0000);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    logic [DW-1:0] old9;
    old9 = sh(9);
    mem[9] = 32'h0BAD_0009;
    clear_log();
    pulse(0);
    pulse(4);
    pulse(1);
    pulse(7);
    check(!chip_start && !acq_en, "R7 acq ignored while busy", acq_en, 0);
    wait_idle(cyc);
    check(wr_cnt == 11 && rd_cnt == 0, "R6 pulses ignored while busy", rd_cnt, 0);
    check(sh(9) == old9, "R6 shadow unchanged by ignored read", sh(9), old9);
  endtask

  task automatic t_acq();
    pulse(7);
    check(chip_start && acq_en && !busy, "R7 start pulse and enable", {chip_start, acq_en, busy}, 3'b110);
    @(negedge clk);
    check(!chip_start && acq_en, "R7 start pulse one cycle", chip_start, 0);
    pulse(8);
    check(!acq_en && !busy, "R7 stop clears enable", acq_en, 0);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) mem[a] = 32'h5A00_0000 + a * 32'h0101_0011;
    for (int k = 0; k < 11; k++) cfg_words[k*DW +: DW] = cfg(k);
    wr_cnt = 0; rd_cnt = 0; prev_cs = 0; prev_strb = 0; run_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_readback();
    t_load();
    t_single_reads();
    t_master_reset();
    t_busy_ignore();
    t_acq();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R6 watchdog: actual busy %0d expected idle", busy);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule